// File: doc/BRIEF.md
# Two-Tier Link Interrupt Aggregator

This block gathers one-cycle event pulses from a set of link channels and turns them into a single active-low interrupt pin. Each link owns a sticky status register and an enable register. A summary tier reduces each link to one bit and gates that bit with a per-link master enable before the pin is driven. Link 0 has two additional group-wide event bits.

Software reaches every register through a plain single-cycle register port. A write takes effect on the clock edge where `reg_wr` is high. The read data is combinational from `reg_addr`. There is no handshake at this port: every access completes in its own cycle, so no back-pressure exists. The event inputs are plain pulses, not streams.

The address map is as follows:
- Address 0 holds the live summary and is read-only.
- Address 1 holds the master enable.
- Link n has its status at address 2+2n and its enable at address 3+2n.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status and enable register reads 0 and `irq_n` is 1.
- R2: A pulse on the event input for link n, category c sets bit c of that link's status on the next clock edge. The bit stays set until software clears it.
- R3: Writing to a link status address clears each status bit whose write-data bit is 1 and leaves the bits written 0 unchanged. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: In each link status register, category c of `link_evt` sits at bit c (bits 0 to 5). Link 0 places `grp_evt[0]` at bit 6 and `grp_evt[1]` at bit 7. On links 1 to 7, bits 6 and 7 always read 0, and so do the matching enable bits.
- R5: Bit n of the summary register (address 0) reads 1 exactly when link n has a status bit that is set and also enabled in its link enable register. The value is live and not latched.
- R6: Writing 0 to a link enable bit drops that link's summary bit at once, while the link status keeps its value.
- R7: Writes to address 0 change no register and have no effect on `irq_n`.
- R8: `irq_n` is registered. After each clock edge it is low exactly when, just before that edge, some summary bit and its master enable bit were both 1.
- R9: Enable registers read back the value written, limited to their implemented bits. Addresses 18 and above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_evt | input | 48 | Event pulses; link n, category c at bit 6n+c |
| grp_evt | input | 2 | Group event pulses, recorded in link 0 bits 6 and 7 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The bench aims at these corner cases, and each one exposes a specific class of fault:
- **Event and clear on the same bit in the same cycle.** A design that lets the clear win loses the event.
- **Writes to the summary address.** A design that latches the summary, or lets such writes disturb it, leaves the pin stuck or cleared.
- **Disabling a link while its status stays set.** A design that latches the summary keeps the pin low.
- **Group bits placed on links other than link 0.** A design that does not mask them shows phantom bits.
- **Pin timing.** The pin is checked one edge after each change, which catches a pin that is combinational or delayed by an extra stage.
- **Random traffic.** This covers mixed enables and partial write-1-to-clear patterns.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DEF_LINKS = 8;
  localparam int unsigned DEF_CAT_W = 6;
  localparam int unsigned DEF_GRP_W = 2;
  localparam int unsigned DEF_REG_W = 8;

  typedef enum logic [2:0] {
    CAT_CELL_LOSS  = 3'd0,
    CAT_FRAME_LOSS = 3'd1,
    CAT_DELAY_SYNC = 3'd2,
    CAT_ID_VIOL    = 3'd3,
    CAT_NEW_CTRL   = 3'd4,
    CAT_OVERFLOW   = 3'd5
  } link_cat_e;
endpackage

// File: rtl/irq_link_cell.sv
module irq_link_cell #(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned CAT_W   = 6,
  parameter int unsigned GRP_W   = 2,
  parameter bit          HAS_GRP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] evt,
  input  logic [REG_W-1:0] clr,
  input  logic             en_we,
  input  logic [REG_W-1:0] en_wdata,
  output logic [REG_W-1:0] stat,
  output logic [REG_W-1:0] en,
  output logic             pend
);
  localparam int unsigned USED_W = HAS_GRP ? (CAT_W + GRP_W) : CAT_W;
  localparam logic [REG_W-1:0] IMPL = REG_W'((1 << USED_W) - 1);

  logic [REG_W-1:0] evt_m, clr_m;
  assign evt_m = evt & IMPL;
  assign clr_m = clr & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
    end else begin
      stat <= (stat & ~clr_m) | evt_m;
      if (en_we) en <= en_wdata & IMPL;
    end
  end

  assign pend = |(stat & en);

  // R2: a pulsed event is recorded on the next edge
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_m) |=> ((stat & $past(evt_m)) == $past(evt_m)));
  // R2: without event or clear the status holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|evt_m) && !(|clr_m)) |=> $stable(stat));
  // R3: a clear with no competing event empties the bit
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_m & ~evt_m)) |=> ((stat & $past(clr_m & ~evt_m)) == '0));
endmodule

// File: rtl/irq_master.sv
module irq_master #(
  parameter int unsigned NUM_LINKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINKS-1:0] link_pend,
  input  logic                 men_we,
  input  logic [NUM_LINKS-1:0] men_wdata,
  output logic [NUM_LINKS-1:0] mstat,
  output logic [NUM_LINKS-1:0] men,
  output logic                 irq_n
);
  assign mstat = link_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men   <= '0;
      irq_n <= 1'b1;
    end else begin
      if (men_we) men <= men_wdata;
      irq_n <= ~|(mstat & men);
    end
  end

  // R8: pin follows the gated summary one edge later
  assert_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_n == !$past(|(mstat & men))));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_LINKS = DEF_LINKS,
  parameter int unsigned CAT_W     = DEF_CAT_W,
  parameter int unsigned GRP_W     = DEF_GRP_W,
  parameter int unsigned REG_W     = DEF_REG_W,
  localparam int unsigned ADDR_W   = $clog2(2 + 2 * NUM_LINKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LINKS*CAT_W-1:0] link_evt,
  input  logic [GRP_W-1:0]           grp_evt,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata,
  output logic                       irq_n
);
  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MEN   = ADDR_W'(1);

  logic [REG_W-1:0]     stat_arr [NUM_LINKS];
  logic [REG_W-1:0]     en_arr   [NUM_LINKS];
  logic [NUM_LINKS-1:0] pend;
  logic [NUM_LINKS-1:0] mstat, men;

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2 + 2 * i);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(3 + 2 * i);
    logic [REG_W-1:0] evt_i;
    logic [REG_W-1:0] clr_i;

    if (i == 0) begin : g_grp
      always_comb begin
        evt_i = '0;
        evt_i[CAT_W-1:0] = link_evt[i*CAT_W +: CAT_W];
        evt_i[CAT_W +: GRP_W] = grp_evt;
      end
    end else begin : g_plain
      always_comb begin
        evt_i = '0;
        evt_i[CAT_W-1:0] = link_evt[i*CAT_W +: CAT_W];
      end
    end

    assign clr_i = (reg_wr && reg_addr == A_STAT) ? reg_wdata : '0;

    irq_link_cell #(
      .REG_W  (REG_W),
      .CAT_W  (CAT_W),
      .GRP_W  (GRP_W),
      .HAS_GRP(i == 0)
    ) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_i),
      .clr     (clr_i),
      .en_we   (reg_wr && reg_addr == A_EN),
      .en_wdata(reg_wdata),
      .stat    (stat_arr[i]),
      .en      (en_arr[i]),
      .pend    (pend[i])
    );
  end

  irq_master #(.NUM_LINKS(NUM_LINKS)) u_master (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_pend(pend),
    .men_we   (reg_wr && reg_addr == A_MEN),
    .men_wdata(reg_wdata[NUM_LINKS-1:0]),
    .mstat    (mstat),
    .men      (men),
    .irq_n    (irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_MSTAT) reg_rdata[NUM_LINKS-1:0] = mstat;
    if (reg_addr == A_MEN)   reg_rdata[NUM_LINKS-1:0] = men;
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (reg_addr == ADDR_W'(2 + 2 * i)) reg_rdata = stat_arr[i];
      if (reg_addr == ADDR_W'(3 + 2 * i)) reg_rdata = en_arr[i];
    end
  end

  // R5: the summary bit reflects the enabled link status bit
  assert_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(2)) |-> (mstat[0] == |(reg_rdata & en_arr[0])));
  // R7: a write to the summary address does not move the master enable
  assert_mwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MSTAT) |=> $stable(men));
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] link_evt = '0;
  logic [1:0]  grp_evt = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_stat [8];
  logic [7:0] m_en   [8];
  logic [7:0] m_men;
  logic       m_irqn;

  always #5 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .link_evt(link_evt), .grp_evt(grp_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  function automatic logic [7:0] impl_mask(int n);
    return (n == 0) ? 8'hFF : 8'h3F;
  endfunction

  function automatic logic [7:0] m_sum();
    logic [7:0] s = '0;
    for (int n = 0; n < 8; n++) s[n] = |(m_stat[n] & m_en[n]);
    return s;
  endfunction

  function automatic logic [7:0] m_read(logic [4:0] a);
    if (a == 0) return m_sum();
    if (a == 1) return m_men;
    for (int n = 0; n < 8; n++) begin
      if (a == 5'(2 + 2 * n)) return m_stat[n];
      if (a == 5'(3 + 2 * n)) return m_en[n];
    end
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [47:0] ev, logic [1:0] ge, logic wr,
                     logic [4:0] a, logic [7:0] d, string tag);
    logic pend;
    @(negedge clk);
    check("R8 irq_n", {7'b0, irq_n}, {7'b0, m_irqn});
    link_evt = ev; grp_evt = ge; reg_wr = wr; reg_addr = a; reg_wdata = d;
    #1;
    check(tag, reg_rdata, m_read(a));
    @(posedge clk);
    pend = |(m_sum() & m_men);
    for (int n = 0; n < 8; n++) begin
      logic [7:0] clr = (wr && a == 5'(2 + 2 * n)) ? (d & impl_mask(n)) : 8'h00;
      logic [7:0] evb = {6'b0, 2'b00} | {2'b00, ev[n*6 +: 6]};
      if (n == 0) evb[7:6] = ge;
      m_stat[n] = (m_stat[n] & ~clr) | (evb & impl_mask(n));
      if (wr && a == 5'(3 + 2 * n)) m_en[n] = d & impl_mask(n);
    end
    if (wr && a == 5'd1) m_men = d;
    m_irqn = !pend;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int n = 0; n < 8; n++) begin m_stat[n] = '0; m_en[n] = '0; end
    m_men = '0; m_irqn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state through every address
    for (int a = 0; a < 20; a++) cyc('0, 2'b00, 1'b0, 5'(a), 8'h00, "R1 reset read");

    // R5/R8: link 3 category 2 with enable; summary bit 3, pin low
    cyc('0, 2'b00, 1'b1, 5'd1, 8'hFF, "R9 men write");
    cyc('0, 2'b00, 1'b1, 5'd9, 8'h04, "R9 link3 en write");
    cyc(48'(1) << (3*6 + 2), 2'b00, 1'b0, 5'd8, 8'h00, "R2 pre-event");
    cyc('0, 2'b00, 1'b0, 5'd8, 8'h00, "R2 link3 status");
    cyc('0, 2'b00, 1'b0, 5'd0, 8'h00, "R5 summary");
    cyc('0, 2'b00, 1'b0, 5'd0, 8'h00, "R8 pin settle");
    // R7: writes to summary address ignored
    cyc('0, 2'b00, 1'b1, 5'd0, 8'h00, "R7 summary write");
    cyc('0, 2'b00, 1'b1, 5'd0, 8'hFF, "R7 summary write again");
    cyc('0, 2'b00, 1'b0, 5'd0, 8'h00, "R7 summary intact");
    // R6: disable link enable, status kept
    cyc('0, 2'b00, 1'b1, 5'd9, 8'h00, "R6 en off");
    cyc('0, 2'b00, 1'b0, 5'd0, 8'h00, "R6 summary dropped");
    cyc('0, 2'b00, 1'b0, 5'd8, 8'h00, "R6 status kept");
    // R4: group events land in link 0 only; upper bits of other links zero
    cyc('0, 2'b11, 1'b0, 5'd2, 8'h00, "R4 grp pre");
    cyc('0, 2'b00, 1'b0, 5'd2, 8'h00, "R4 link0 grp bits");
    cyc('0, 2'b00, 1'b1, 5'd5, 8'hFF, "R4 link1 en write");
    cyc('0, 2'b00, 1'b0, 5'd5, 8'h00, "R4 link1 en masked");
    // R3: event and clear collide on link 5 bit 1
    cyc(48'(1) << (5*6 + 1), 2'b00, 1'b0, 5'd12, 8'h00, "R3 set");
    cyc(48'(1) << (5*6 + 1), 2'b00, 1'b1, 5'd12, 8'h02, "R3 collide");
    cyc('0, 2'b00, 1'b0, 5'd12, 8'h00, "R3 event wins");
    cyc('0, 2'b00, 1'b1, 5'd12, 8'h02, "R3 clear");
    cyc('0, 2'b00, 1'b0, 5'd12, 8'h00, "R3 cleared");
    // R9: unused addresses
    cyc('0, 2'b00, 1'b1, 5'd20, 8'hAA, "R9 unused write");
    cyc('0, 2'b00, 1'b0, 5'd20, 8'h00, "R9 unused read");

    // Random traffic: R2 R3 R5 R8 R9
    for (int k = 0; k < 4000; k++) begin
      logic [47:0] ev = '0;
      logic [1:0]  ge;
      for (int b = 0; b < 48; b++) ev[b] = ($urandom % 40) == 0;
      ge[0] = ($urandom % 30) == 0;
      ge[1] = ($urandom % 30) == 0;
      cyc(ev, ge, ($urandom % 3) == 0, 5'($urandom % 20), 8'($urandom),
          "R2 R3 R5 R9 random");
    end
    cyc('0, 2'b00, 1'b0, 5'd0, 8'h00, "R8 final");
    summary();
  end
endmodule